// File: doc/BRIEF.md
# Vector Two-Source Unzip Permute Unit

This block separates the interleaved elements of two source vectors into two destination vectors in one operation. The even result gathers every even-indexed element: those of the first source fill its lower half, and those of the second source fill its upper half. The odd result gathers the odd-indexed elements in the same arrangement. The element width is chosen at run time. A 2-bit size code selects 8, 16, 32 or 64 bits, and a separate wide-mode select fixes the width at 128 bits.

The vector length is also supplied at run time, as a bit count. The unit checks the length and the element width against each other. It does not fill a register file. It only returns the two result vectors and the even/odd destination register pair they are meant for. Every request produces exactly one response one clock later, whether the request is legal or not. The operation has no predicate, so every element position below the vector length is written.

Top module: `unzip_pair_unit`

## Requirements
- R1: Element width in bits is 8 << size_code (code 0 = 8, 1 = 16, 2 = 32, 3 = 64). When wide_mode is 1 the width is 128 bits and size_code is ignored.
- R2: With pairs = VL / (2 * width), element p of res_even (p < pairs) holds element 2p of src_a, and element pairs+p holds element 2p of src_b. Element k occupies bits [k*width +: width].
- R3: Element p of res_odd holds element 2p+1 of src_a, and element pairs+p holds element 2p+1 of src_b.
- R4: Every result bit at position VL or above is zero.
- R5: vl_bits is legal only if it is a power of two from 128 to MAX_VL. Any other value raises illegal.
- R6: illegal is raised when VL is less than twice the element width (for example, wide mode at VL 128). Wide mode is always illegal when MAX_VL is below 256.
- R7: When illegal is raised, both results are zero and out_valid still pulses.
- R8: dst_first equals 2 * dst_field, and dst_second equals 2 * dst_field + 1.
- R9: out_valid is high exactly in the cycle after an in_valid cycle. All outputs hold their values while in_valid is low.
- R10: rst is synchronous and active high. It clears out_valid, illegal, both results and both destination indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | MAX_VL | First source vector |
| src_b | input | MAX_VL | Second source vector |
| size_code | input | 2 | Element width code |
| wide_mode | input | 1 | Selects 128-bit elements |
| vl_bits | input | VLW | Current vector length in bits |
| dst_field | input | DF_W | Encoded destination pair field |
| out_valid | output | 1 | Response strobe |
| res_even | output | MAX_VL | Even-element result |
| res_odd | output | MAX_VL | Odd-element result |
| dst_first | output | DF_W+1 | First destination register index |
| dst_second | output | DF_W+1 | Second destination register index |
| illegal | output | 1 | Operation rejected |

## Verification
The bench targets the boundaries of the length check. These are VL 128 with 64-bit and 128-bit elements, VL equal to MAX_VL, and lengths that are not powers of two, zero, or below 128. A faulty check would either accept these lengths and return data, or reject a legal operation and zero its results. Random mixes of width and length expose a wrong half boundary, which would put src_b elements at the wrong offset, and a swapped odd/even selection. Stale bits left above a short VL after a long one show up as nonzero high bits. An idle cycle after each request would reveal outputs that change without a strobe.

// File: rtl/unzip_pkg.sv
package unzip_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_code_e;

    // log2 of element width in bytes: 0..4
    typedef logic [2:0] elem_lg_t;

    localparam elem_lg_t LG_WIDE = 3'd4;

    typedef struct packed {
        logic     bad;
        elem_lg_t lg;
    } op_chk_t;

    function automatic elem_lg_t pick_lg(input size_code_e sz, input logic wide);
        elem_lg_t lg;
        if (wide) lg = LG_WIDE;
        else      lg = {1'b0, sz};
        return lg;
    endfunction

    // Source byte index for result byte j, given half-length in bytes.
    function automatic int unsigned src_byte(input int unsigned j,
                                             input int unsigned half,
                                             input elem_lg_t lg,
                                             input logic odd);
        int unsigned jj;
        int unsigned e;
        int unsigned k;
        jj = (j >= half) ? (j - half) : j;
        e  = jj >> lg;
        k  = jj & ((32'd1 << lg) - 32'd1);
        return (((e << 1) + {31'd0, odd}) << lg) + k;
    endfunction

endpackage

// File: rtl/unzip_legal_check.sv
module unzip_legal_check
    import unzip_pkg::*;
#(
    parameter int MAX_VL = 2048,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input  logic [VLW-1:0] vl_i,
    input  logic [1:0]     size_i,
    input  logic           wide_i,
    output op_chk_t        chk_o
);
    localparam bit WIDE_OK = (MAX_VL >= 256);
    localparam int MIN_VL  = 128;

    elem_lg_t    lg;
    logic        len_ok;
    logic        fit_ok;
    int unsigned need_bits;

    always_comb begin
        lg        = pick_lg(size_code_e'(size_i), wide_i);
        need_bits = 32'd16 << lg;
        len_ok    = (vl_i != '0)
                 && ((vl_i & (vl_i - 1'b1)) == '0)
                 && (32'(vl_i) >= 32'(MIN_VL))
                 && (32'(vl_i) <= 32'(MAX_VL));
        fit_ok    = 32'(vl_i) >= need_bits;
        chk_o.lg  = lg;
        chk_o.bad = !len_ok || !fit_ok || (wide_i && !WIDE_OK);
    end
endmodule

// File: rtl/unzip_byte_net.sv
module unzip_byte_net
    import unzip_pkg::*;
#(
    parameter int   MAX_VL = 2048,
    parameter int   VLW    = $clog2(MAX_VL) + 1,
    parameter logic ODD    = 1'b0
) (
    input  logic [MAX_VL-1:0] a_i,
    input  logic [MAX_VL-1:0] b_i,
    input  logic [VLW-1:0]    vl_i,
    input  elem_lg_t          lg_i,
    output logic [MAX_VL-1:0] res_o
);
    localparam int NBYTES = MAX_VL / 8;

    int unsigned vbytes;
    int unsigned half;

    always_comb begin
        vbytes = 32'(vl_i) >> 3;
        half   = 32'(vl_i) >> 4;
        res_o  = '0;
        for (int j = 0; j < NBYTES; j++) begin
            int unsigned idx;
            idx = src_byte(j, half, lg_i, ODD) % NBYTES;
            if (j < vbytes) begin
                if (j < half) res_o[j*8 +: 8] = a_i[idx*8 +: 8];
                else          res_o[j*8 +: 8] = b_i[idx*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/unzip_pair_unit.sv
module unzip_pair_unit
    import unzip_pkg::*;
#(
    parameter int MAX_VL = 2048,
    parameter int DF_W   = 4,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [MAX_VL-1:0] src_a,
    input  logic [MAX_VL-1:0] src_b,
    input  logic [1:0]        size_code,
    input  logic              wide_mode,
    input  logic [VLW-1:0]    vl_bits,
    input  logic [DF_W-1:0]   dst_field,
    output logic              out_valid,
    output logic [MAX_VL-1:0] res_even,
    output logic [MAX_VL-1:0] res_odd,
    output logic [DF_W:0]     dst_first,
    output logic [DF_W:0]     dst_second,
    output logic              illegal
);
    op_chk_t           chk;
    logic [MAX_VL-1:0] net_res [2];

    unzip_legal_check #(.MAX_VL(MAX_VL), .VLW(VLW)) u_chk (
        .vl_i   (vl_bits),
        .size_i (size_code),
        .wide_i (wide_mode),
        .chk_o  (chk)
    );

    for (genvar g = 0; g < 2; g++) begin : g_net
        unzip_byte_net #(.MAX_VL(MAX_VL), .VLW(VLW), .ODD(g[0])) u_net (
            .a_i   (src_a),
            .b_i   (src_b),
            .vl_i  (vl_bits),
            .lg_i  (chk.lg),
            .res_o (net_res[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            illegal    <= 1'b0;
            res_even   <= '0;
            res_odd    <= '0;
            dst_first  <= '0;
            dst_second <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                illegal    <= chk.bad;
                res_even   <= chk.bad ? '0 : net_res[0];
                res_odd    <= chk.bad ? '0 : net_res[1];
                dst_first  <= {dst_field, 1'b0};
                dst_second <= {dst_field, 1'b1};
            end
        end
    end
endmodule

// File: rtl/unzip_pair_checker.sv
module unzip_pair_checker #(
    parameter int MAX_VL = 2048,
    parameter int DF_W   = 4,
    parameter int VLW    = $clog2(MAX_VL) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              wide_mode,
    input logic [VLW-1:0]    vl_bits,
    input logic [DF_W-1:0]   dst_field,
    input logic              out_valid,
    input logic [MAX_VL-1:0] res_even,
    input logic [MAX_VL-1:0] res_odd,
    input logic [DF_W:0]     dst_first,
    input logic [DF_W:0]     dst_second,
    input logic              illegal
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_even) && $stable(res_odd) && $stable(illegal)));
    a_r7_zero_on_illegal: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (res_even == '0 && res_odd == '0));
    a_r4_above_vl_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((res_even >> $past(vl_bits)) == '0
                   && (res_odd  >> $past(vl_bits)) == '0));
    a_r6_wide_short_vl: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wide_mode && vl_bits == VLW'(128)) |=> illegal);
    a_r8_pair_index: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (dst_first == {$past(dst_field), 1'b0}
                   && dst_second == dst_first + 1'b1));
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !illegal));
endmodule

bind unzip_pair_unit unzip_pair_checker #(.MAX_VL(MAX_VL), .DF_W(DF_W), .VLW(VLW)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .wide_mode  (wide_mode),
    .vl_bits    (vl_bits),
    .dst_field  (dst_field),
    .out_valid  (out_valid),
    .res_even   (res_even),
    .res_odd    (res_odd),
    .dst_first  (dst_first),
    .dst_second (dst_second),
    .illegal    (illegal)
);

// File: tb/sim_unzip_pair_unit.sv
module sim_unzip_pair_unit;
    localparam int MV  = 2048;
    localparam int DFW = 4;
    localparam int VW  = $clog2(MV) + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [MV-1:0] src_a, src_b;
    logic [1:0]    size_code;
    logic          wide_mode;
    logic [VW-1:0] vl_bits;
    logic [DFW-1:0] dst_field;
    logic          out_valid;
    logic [MV-1:0] res_even, res_odd;
    logic [DFW:0]  dst_first, dst_second;
    logic          illegal;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    unzip_pair_unit #(.MAX_VL(MV), .DF_W(DFW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .size_code(size_code), .wide_mode(wide_mode), .vl_bits(vl_bits),
        .dst_field(dst_field), .out_valid(out_valid), .res_even(res_even),
        .res_odd(res_odd), .dst_first(dst_first), .dst_second(dst_second),
        .illegal(illegal)
    );

    function automatic int ew(input logic [1:0] sz, input logic wd);
        return wd ? 128 : (8 << sz);
    endfunction

    function automatic logic exp_bad(input logic [1:0] sz, input logic wd, input int vl);
        int w;
        logic ok;
        w  = ew(sz, wd);
        ok = 1'b0;
        for (int s = 128; s <= MV; s = s * 2) if (vl == s) ok = 1'b1;
        if (vl < 2 * w) ok = 1'b0;
        if (wd && MV < 256) ok = 1'b0;
        return !ok;
    endfunction

    function automatic logic [MV-1:0] exp_res(input logic [MV-1:0] a, input logic [MV-1:0] b,
                                             input logic [1:0] sz, input logic wd,
                                             input int vl, input int odd);
        logic [MV-1:0] r;
        int w, pairs;
        r = '0;
        if (exp_bad(sz, wd, vl)) return r;
        w = ew(sz, wd);
        pairs = vl / (2 * w);
        for (int p = 0; p < pairs; p++)
            for (int k = 0; k < w; k++) begin
                r[p*w + k]           = a[(2*p + odd)*w + k];
                r[(pairs + p)*w + k] = b[(2*p + odd)*w + k];
            end
        return r;
    endfunction

    function automatic logic [MV-1:0] rnd_vec();
        logic [MV-1:0] v;
        for (int i = 0; i < MV / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk_vec(input string req, input logic [MV-1:0] act, input logic [MV-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] sz, input logic wd, input int vl, input logic [DFW-1:0] df);
        logic [MV-1:0] a, b, e0, e1;
        logic bad;
        a = rnd_vec(); b = rnd_vec();
        @(negedge clk);
        src_a = a; src_b = b; size_code = sz; wide_mode = wd;
        vl_bits = VW'(vl); dst_field = df; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        bad = exp_bad(sz, wd, vl);
        e0 = exp_res(a, b, sz, wd, vl, 0);
        e1 = exp_res(a, b, sz, wd, vl, 1);
        chk_val("R9 out_valid pulse", 32'(out_valid), 32'd1);
        chk_val("R5 R6 illegal flag", 32'(illegal), 32'(bad));
        chk_vec(bad ? "R7 even zeroed" : "R1 R2 R4 even result", res_even, e0);
        chk_vec(bad ? "R7 odd zeroed" : "R1 R3 R4 odd result", res_odd, e1);
        chk_val("R8 dst_first", 32'(dst_first), 32'(df) * 2);
        chk_val("R8 dst_second", 32'(dst_second), 32'(df) * 2 + 1);
        src_a = rnd_vec(); src_b = rnd_vec(); size_code = ~sz; vl_bits = VW'(128);
        @(negedge clk);
        chk_val("R9 no pulse when idle", 32'(out_valid), 32'd0);
        chk_vec("R9 even holds", res_even, e0);
        chk_vec("R9 odd holds", res_odd, e1);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0;
        size_code = 2'd0; wide_mode = 1'b0; vl_bits = VW'(128); dst_field = '0;
        repeat (3) @(negedge clk);
        chk_val("R10 reset valid", 32'(out_valid), 32'd0);
        chk_val("R10 reset illegal", 32'(illegal), 32'd0);
        chk_vec("R10 reset even", res_even, '0);
        chk_val("R10 reset dst", 32'(dst_first), 32'd0);
        rst = 1'b0;
        // directed corners
        for (int s = 0; s < 4; s++) run_op(2'(s), 1'b0, 128, 4'(s));   // R1 every code at VL 128
        run_op(2'd0, 1'b1, 128, 4'd15);     // R6 wide too short
        run_op(2'd3, 1'b1, 256, 4'd7);      // R1 wide legal, size code ignored
        run_op(2'd0, 1'b0, MV, 4'd3);       // R2 max length bytes
        run_op(2'd2, 1'b1, MV, 4'd9);       // wide at max
        run_op(2'd0, 1'b0, 384, 4'd1);      // R5 not power of two
        run_op(2'd1, 1'b0, 64, 4'd2);       // R5 below minimum
        run_op(2'd1, 1'b0, 0, 4'd2);        // R5 zero
        run_op(2'd2, 1'b0, 4096 - 1, 4'd4); // R5 out of range
        run_op(2'd0, 1'b0, MV, 4'd5);
        run_op(2'd0, 1'b0, 128, 4'd6);      // R4 short after long
        // random mix
        for (int i = 0; i < 150; i++) begin
            int vl;
            vl = 128 << ($urandom % 5);
            if ($urandom % 8 == 0) vl = $urandom % 2100;
            run_op(2'($urandom), ($urandom % 4) == 0, vl, 4'($urandom));
        end
        // R10 reset mid-stream clears the response
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_val("R10 reset clears valid", 32'(out_valid), 32'd0);
        chk_vec("R10 reset clears odd", res_odd, '0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule